// File: doc/BRIEF.md
# Programmable-Width LSB-First Serializer

This block turns parallel words taken from a first-word-fall-through FIFO into a serial bit stream. It drives one bit per rising edge of the serial clock, least significant bit first. A two-bit length select sets how many low bits of each 9-bit word go out: 5, 7, 8 or 9. A bank of four marker outputs behaves like a tapped delay line. Each marker is cleared when a word starts and is set on the clock that presents its bit position (4, 6, 7 or 8). The marker for the selected length closes the word. When the FIFO still has data at that point, the next word is loaded on the very next edge with no gap.

Several instances can share one serial line to build wider words. Each instance drives the line only during its own bit slot, and `ser_oe` shows when it does. An instance built with `LEAD = 1` begins a word whenever it is free, a word is available and `cascade_in` is high. A standalone instance ties `cascade_in` high. In a chain, the leader's `cascade_in` comes from the last instance's closing marker. A follower (`LEAD = 0`) begins a word only when `cascade_in` shows a rising transition, and is normally fed from the previous instance's bit-8 marker. The word-fetch output is combinational. It tells the FIFO that the word on `fifo_word` is consumed at the next rising edge.

Top module: `lsb_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, the block leaves that edge with `ser_oe` low, `ser_out` low and all four markers high (`markers` = 4'b1111). `fetch` is low while `rst` is high.
- R2: After the edge that loads word W, `ser_out` carries W[k] in the k-th following cycle (k = 0 first), with `ser_oe` high throughout.
- R3: `len_sel` encodes the word length as 00 = 5, 01 = 7, 10 = 8 and 11 = 9 bits. `ser_oe` stays high for exactly that many cycles when no further word follows.
- R4: `markers[0..3]` belong to bit positions 4, 6, 7 and 8. All markers go low on the load edge. Marker i goes high on the edge that presents its position, and it stays high until the next load. Markers beyond the word length stay low.
- R5: If a word is available in the cycle that presents the last bit, the next word is loaded on the following edge and its bit 0 follows without a gap.
- R6: While `fifo_empty` is high, no word is loaded and `fetch` stays low. After the last bit of the last word, `ser_oe` drops and `ser_out` is low.
- R7: The length is captured at the load edge. A change of `len_sel` during a word has no effect on that word.
- R8: `fetch` is high in exactly the cycles where a word is loaded at the next rising edge. It stays low while a word is still being shifted and is not at its last bit.
- R9: A leading instance (`LEAD = 1`) loads only while `cascade_in` is high. With `cascade_in` low it stays idle even when a word is available.
- R10: A following instance (`LEAD = 0`) loads only in a cycle where `cascade_in` is high and was low in the previous cycle. `cascade_in` held high does not start another word.
- R11: A leader of length 9 chained with a follower produces one contiguous combined word on the shared line: the leader's bits 0..8, then the follower's bits. Exactly one instance drives in each slot. The leader starts again once the follower's closing marker is high and a word is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fifo_word | input | DW | Word at the head of the FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| len_sel | input | 2 | Word length: 00=5, 01=7, 10=8, 11=9 bits |
| cascade_in | input | 1 | Start qualifier: level for a leader, rising transition for a follower |
| ser_out | output | 1 | Serial data, low when not driving |
| ser_oe | output | 1 | Drive enable for the shared serial line |
| markers | output | 4 | Delay-line markers for bit positions 4, 6, 7, 8 |
| fetch | output | 1 | Word consumed from the FIFO at the next rising edge |

## Verification
The embedded assertions check cycle relations on every edge. A load clears all markers and raises the enable. Markers only rise within a word. A closing cycle is followed by an idle slot or by a fresh load, depending on whether a word was fetched. An idle instance stays idle while the FIFO is empty, or while a leader's cascade input is low. A follower only starts after a low-to-high step on its cascade input. The bit order on the line, the exact length for each select code, the marker pattern at each position and the joined output of a two-instance chain depend on the data and the timing of a whole word. Only the bench's directed scenarios show these.

// File: rtl/lsbser_pkg.sv
package lsbser_pkg;

    localparam int unsigned WORD_W  = 9;
    localparam int unsigned N_MARK  = 4;
    localparam int unsigned SEL_W   = $clog2(N_MARK);

    typedef enum logic [SEL_W-1:0] {
        LEN_5 = 2'b00,
        LEN_7 = 2'b01,
        LEN_8 = 2'b10,
        LEN_9 = 2'b11
    } len_sel_e;

    // Bit position marked by marker idx for a word of dw bits.
    function automatic int unsigned mark_pos(int unsigned dw, int unsigned idx);
        return (idx == 0) ? (dw - 5) : (dw - 4 + idx);
    endfunction

endpackage

// File: rtl/lsbser_start.sv
module lsbser_start
    import lsbser_pkg::*;
#(
    parameter bit LEAD = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic cascade_in,
    input  logic fifo_empty,
    input  logic slot_free,
    output logic load
);

    logic casc_q;
    logic go;

    always_ff @(posedge clk) begin
        if (rst) casc_q <= 1'b1;
        else     casc_q <= cascade_in;
    end

    generate
        if (LEAD) begin : g_level
            assign go = cascade_in;
        end else begin : g_edge
            assign go = cascade_in & ~casc_q;
        end
    endgenerate

    assign load = ~rst & slot_free & go & ~fifo_empty;

    generate
        if (!LEAD) begin : g_follow_chk
            // R10: a follower only starts right after a low-to-high step.
            assert_follow_edge_R10: assert property (@(posedge clk) disable iff (rst)
                load |-> (cascade_in && !$past(cascade_in)));
        end
    endgenerate

endmodule

// File: rtl/lsbser_marker_line.sv
module lsbser_marker_line
    import lsbser_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEL_W-1:0]  len_sel,
    output logic              busy,
    output logic              at_last,
    output logic [N_MARK-1:0] markers
);

    localparam int unsigned CW = $clog2(DW);

    logic [CW-1:0]    pos;
    logic [SEL_W-1:0] sel_q;
    logic [CW-1:0]    last_pos;
    logic [CW-1:0]    pos_nx;

    assign last_pos = CW'(mark_pos(DW, int'(sel_q)));
    assign at_last  = busy && (pos == last_pos);
    assign pos_nx   = pos + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            pos   <= '0;
            sel_q <= LEN_9;
        end else if (load) begin
            busy  <= 1'b1;
            pos   <= '0;
            sel_q <= len_sel;
        end else if (at_last) begin
            busy  <= 1'b0;
        end else if (busy) begin
            pos   <= pos_nx;
        end
    end

    generate
        for (genvar i = 0; i < N_MARK; i++) begin : g_mark
            localparam logic [CW-1:0] MPOS = CW'(mark_pos(DW, i));
            logic mark_r;
            always_ff @(posedge clk) begin
                if (rst)
                    mark_r <= 1'b1;
                else if (load)
                    mark_r <= 1'b0;
                else if (busy && !at_last && (pos_nx == MPOS))
                    mark_r <= 1'b1;
            end
            assign markers[i] = mark_r;
        end
    endgenerate

    // R3: the closing cycle is followed by idle or by a fresh word.
    assert_word_close_R3: assert property (@(posedge clk) disable iff (rst)
        at_last |=> (!busy || pos == '0));

    // R4: within a word, markers never fall.
    assert_marker_rise_only_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> ((markers & $past(markers)) == $past(markers)));

endmodule

// File: rtl/lsbser_shifter.sv
module lsbser_shifter
    import lsbser_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  logic [DW-1:0] word,
    output logic          bit_out
);

    logic [DW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)          sreg <= '0;
        else if (load)    sreg <= word;
        else if (advance) sreg <= {1'b0, sreg[DW-1:1]};
    end

    assign bit_out = sreg[0];

endmodule

// File: rtl/lsb_serializer.sv
module lsb_serializer
    import lsbser_pkg::*;
#(
    parameter int unsigned DW   = WORD_W,
    parameter bit          LEAD = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     fifo_word,
    input  logic              fifo_empty,
    input  logic [SEL_W-1:0]  len_sel,
    input  logic              cascade_in,
    output logic              ser_out,
    output logic              ser_oe,
    output logic [N_MARK-1:0] markers,
    output logic              fetch
);

    logic busy;
    logic at_last;
    logic load;
    logic sbit;

    lsbser_start #(.LEAD(LEAD)) u_start (
        .clk        (clk),
        .rst        (rst),
        .cascade_in (cascade_in),
        .fifo_empty (fifo_empty),
        .slot_free  (~busy | at_last),
        .load       (load)
    );

    lsbser_marker_line #(.DW(DW)) u_line (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .len_sel (len_sel),
        .busy    (busy),
        .at_last (at_last),
        .markers (markers)
    );

    lsbser_shifter #(.DW(DW)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (busy & ~at_last),
        .word    (fifo_word),
        .bit_out (sbit)
    );

    assign fetch   = load;
    assign ser_oe  = busy;
    assign ser_out = busy & sbit;

    // R4: a load edge clears every marker and opens the bit slot.
    assert_load_clears_R4: assert property (@(posedge clk) disable iff (rst)
        fetch |=> (markers == '0 && ser_oe));

    // R5: closing without a fetch releases the line.
    assert_close_release_R5: assert property (@(posedge clk) disable iff (rst)
        (at_last && !fetch) |=> !ser_oe);

    // R6: an idle instance stays idle while the FIFO is empty.
    assert_hold_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (!ser_oe && fifo_empty) |=> !ser_oe);

    generate
        if (LEAD) begin : g_lead_chk
            // R9: a leader waits while its cascade input is low.
            assert_lead_wait_R9: assert property (@(posedge clk) disable iff (rst)
                (!ser_oe && !cascade_in) |=> !ser_oe);
        end
    endgenerate

endmodule

// File: tb/test_lsb_serializer.sv
module test_lsb_serializer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    logic [8:0] word_a = '0, word_b = '0;
    logic       empty_a = 1'b1, empty_b = 1'b1;
    logic [1:0] sel_a = 2'b11, sel_b = 2'b01;
    logic       casc_a_drv = 1'b1, casc_b_drv = 1'b1, casc_mode = 1'b0;
    logic       out_a, oe_a, fetch_a, out_b, oe_b, fetch_b;
    logic [3:0] mk_a, mk_b;
    logic       casc_a, casc_b;

    always #10 clk = ~clk;

    assign casc_a = casc_mode ? mk_b[sel_b] : casc_a_drv;
    assign casc_b = casc_mode ? mk_a[3]     : casc_b_drv;

    lsb_serializer #(.DW(9), .LEAD(1'b1)) i_lsb_serializer (
        .clk(clk), .rst(rst), .fifo_word(word_a), .fifo_empty(empty_a),
        .len_sel(sel_a), .cascade_in(casc_a), .ser_out(out_a),
        .ser_oe(oe_a), .markers(mk_a), .fetch(fetch_a)
    );

    lsb_serializer #(.DW(9), .LEAD(1'b0)) i_lsb_serializer_f (
        .clk(clk), .rst(rst), .fifo_word(word_b), .fifo_empty(empty_b),
        .len_sel(sel_b), .cascade_in(casc_b), .ser_out(out_b),
        .ser_oe(oe_b), .markers(mk_b), .fetch(fetch_b)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'b00:   return 5;
            2'b01:   return 7;
            2'b10:   return 8;
            default: return 9;
        endcase
    endfunction

    function automatic logic [3:0] mark_exp(input int k);
        int pos[4] = '{4, 6, 7, 8};
        logic [3:0] m = '0;
        for (int i = 0; i < 4; i++) if (pos[i] <= k) m[i] = 1'b1;
        return m;
    endfunction

    // Called in the cycle after the load edge; ends in the last-bit cycle.
    task automatic expect_word(input logic [8:0] w, input int len, input string req);
        for (int k = 0; k < len; k++) begin
            if (k > 0) tick();
            chk({req, " oe"}, oe_a, 1);
            chk({req, " bit"}, out_a, w[k]);
            chk("R4 markers", mk_a, mark_exp(k));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        empty_a = 1'b0;
        tick();
        #1;
        chk("R1 oe", oe_a, 0);
        chk("R1 out", out_a, 0);
        chk("R1 markers", mk_a, 4'b1111);
        chk("R1 fetch", fetch_a, 0);
        chk("R1 follower markers", mk_b, 4'b1111);
        empty_a = 1'b1;
        rst = 1'b0;
        tick();
    endtask

    task automatic t_width(input logic [1:0] s, input logic [8:0] w);
        int len = len_of(s);
        sel_a = s;
        word_a = w;
        empty_a = 1'b0;
        #1;
        chk("R8 fetch", fetch_a, 1);
        tick();
        empty_a = 1'b1;
        expect_word(w, len, "R3/R2");
        chk("R6 no fetch when empty", fetch_a, 0);
        tick();
        chk("R3 length end", oe_a, 0);
        chk("R6 released out", out_a, 0);
        chk("R4 final markers", mk_a, mark_exp(len - 1));
    endtask

    task automatic t_back_to_back();
        sel_a = 2'b10;
        word_a = 9'h0B6;
        empty_a = 1'b0;
        tick();
        word_a = 9'h149;
        #1;
        chk("R8 no fetch mid-word", fetch_a, 0);
        expect_word(9'h0B6, 8, "R5 first");
        #1;
        chk("R5 fetch at last bit", fetch_a, 1);
        tick();
        empty_a = 1'b1;
        expect_word(9'h149, 8, "R5 second");
        tick();
        chk("R5 end", oe_a, 0);
    endtask

    task automatic t_len_change();
        sel_a = 2'b00;
        word_a = 9'h0F5;
        empty_a = 1'b0;
        tick();
        empty_a = 1'b1;
        sel_a = 2'b11;
        expect_word(9'h0F5, 5, "R7");
        tick();
        chk("R7 captured length", oe_a, 0);
    endtask

    task automatic t_lead_block();
        sel_a = 2'b11;
        casc_a_drv = 1'b0;
        word_a = 9'h12D;
        empty_a = 1'b0;
        #1;
        chk("R9 no fetch", fetch_a, 0);
        tick();
        chk("R9 idle", oe_a, 0);
        tick();
        chk("R9 still idle", oe_a, 0);
        casc_a_drv = 1'b1;
        #1;
        chk("R9 fetch", fetch_a, 1);
        tick();
        empty_a = 1'b1;
        expect_word(9'h12D, 9, "R9");
        tick();
    endtask

    task automatic t_follower();
        sel_b = 2'b01;
        word_b = 9'h05A;
        empty_b = 1'b0;
        #1;
        chk("R10 level no fetch", fetch_b, 0);
        tick();
        chk("R10 idle", oe_b, 0);
        casc_b_drv = 1'b0;
        #1;
        chk("R10 low no fetch", fetch_b, 0);
        tick();
        casc_b_drv = 1'b1;
        #1;
        chk("R10 rise fetch", fetch_b, 1);
        tick();
        empty_b = 1'b1;
        for (int k = 0; k < 7; k++) begin
            if (k > 0) tick();
            chk("R10 oe", oe_b, 1);
            chk("R10 bit", out_b, word_b[k]);
        end
        tick();
        chk("R10 end", oe_b, 0);
        empty_b = 1'b0;
        #1;
        chk("R10 held high no fetch", fetch_b, 0);
        tick();
        chk("R10 held high idle", oe_b, 0);
        empty_b = 1'b1;
    endtask

    task automatic t_cascade();
        logic [15:0] joined;
        logic        line;
        casc_mode = 1'b1;
        sel_a = 2'b11;
        sel_b = 2'b01;
        word_a = 9'h1C3;
        word_b = 9'h05A;
        empty_a = 1'b1;
        empty_b = 1'b1;
        do_reset();
        joined = {word_b[6:0], word_a};
        empty_a = 1'b0;
        empty_b = 1'b0;
        #1;
        chk("R11 leader fetch", fetch_a, 1);
        chk("R11 follower waits", fetch_b, 0);
        tick();
        empty_a = 1'b1;
        for (int k = 0; k < 16; k++) begin
            if (k > 0) tick();
            if (k == 9) empty_b = 1'b1;
            line = oe_a ? out_a : (oe_b ? out_b : 1'b0);
            chk("R11 line bit", line, joined[k]);
            chk("R11 one driver", oe_a + oe_b, 1);
            if (k == 8) chk("R11 follower fetch", fetch_b, 1);
        end
        tick();
        chk("R11 line released", oe_a + oe_b, 0);
        empty_a = 1'b0;
        #1;
        chk("R11 leader restart", fetch_a, 1);
        tick();
        empty_a = 1'b1;
        chk("R11 leader drives", oe_a, 1);
        repeat (12) tick();
        casc_mode = 1'b0;
    endtask

    initial begin
        do_reset();
        t_reset();
        t_width(2'b00, 9'h1A5);
        t_width(2'b01, 9'h0D3);
        t_width(2'b10, 9'h16E);
        t_width(2'b11, 9'h1B9);
        t_back_to_back();
        t_len_change();
        t_lead_block();
        t_follower();
        t_cascade();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule